// File: doc/BRIEF.md
# Memory Bit Set Sequencer

This block carries out a single "test and set one bit in memory" operation. When a start strobe is accepted, it adds a sign-extended displacement to a base value to get a byte address. It then reads that byte over a simple synchronous byte-wide memory port and writes it back with one selected bit forced high. The other bits of the byte are written back unchanged.

The value the selected bit had before the write is reported on a zero-flag output as its inverse. The flag is 1 when the bit was clear and 0 when it was already set. No other status is produced.

The whole operation takes a fixed four cycles after the start is accepted. Those cycles are an address phase, a read phase, a modify-and-write phase and a completion cycle that pulses done. The block is meant to sit beside an execution pipeline that holds off until done arrives.

Top module: `bitset_rmw`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, done, read enable and write enable are 0, and the zero flag is 0.
- R2: The memory address equals base plus the displacement sign-extended from 16 to 32 bits, modulo 2^32. It is presented during both the read cycle and the write cycle.
- R3: Read enable is high for exactly one cycle, the second cycle after the accepting clock edge. In the first cycle after acceptance (the address phase), read enable, write enable and done are all 0.
- R4: Write enable is high for exactly one cycle, the cycle right after the read cycle. The write data equals the byte returned by the read, OR'ed with a one-hot mask that has bit n set, where n (0 to 7) is the 3-bit bit number and bit 0 is the least significant bit.
- R5: The zero flag becomes the inverse of the selected bit of the byte that was read. It is visible from the done cycle onward and changes only in a done cycle.
- R6: Done is a one-cycle pulse in the fourth cycle after the accepting edge, that is, the cycle right after the write cycle.
- R7: The start strobe is accepted only when the block is idle. A start, or a change of base, displacement or bit number, at any point from acceptance through the done cycle has no effect on the address, the data or the number of memory accesses.
- R8: A write never occurs unless it is directly preceded by a read in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, sampled only when idle |
| base | input | 32 | Base address value |
| disp | input | 16 | Signed displacement |
| bit_sel | input | 3 | Number of the bit to set within the byte |
| mem_addr | output | 32 | Byte address to memory |
| mem_rd_en | output | 1 | Read enable; data is returned on the next cycle |
| mem_rdata | input | 8 | Read data from memory |
| mem_wr_en | output | 1 | Write enable |
| mem_wdata | output | 8 | Write data to memory |
| z_flag | output | 1 | Inverse of the old value of the selected bit |
| done | output | 1 | Completion pulse |

## Verification
Each pattern in the table is chosen to separate one kind of fault from the others.

Addresses are tried with a small positive displacement, a displacement of minus one, the most negative displacement and the most positive displacement, and with a base near the top of the address space that wraps to zero. Together these show whether the sign extension and the carry are correct.

Bit numbers 0, 2, 3, 5, 6 and 7 are used against bytes in which the chosen bit is either clear or already set, and the surrounding bits are mixed. This separates a wrong mask position, a clobbered neighbour bit and an inverted zero flag.

A run that keeps start high and changes its operands in the middle of the operation shows whether a busy block ignores the request. The same run checks that exactly one read takes place.

// File: rtl/bitset_pkg.sv
package bitset_pkg;
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_ADDR  = 3'd1,
      PH_READ  = 3'd2,
      PH_WRITE = 3'd3,
      PH_DONE  = 3'd4
   } phase_t;
endpackage

// File: rtl/bitset_addr.sv
// Effective address unit: base plus sign-extended displacement, registered.
module bitset_addr #(
   parameter int ADDR_W = 32,
   parameter int DISP_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [DISP_W-1:0] disp_i,
   output logic [ADDR_W-1:0] addr_o
);
   logic [ADDR_W-1:0] disp_ext;
   logic [ADDR_W-1:0] addr_q;

   generate
      if (DISP_W < ADDR_W) begin : g_sext
         localparam int PAD_W = ADDR_W - DISP_W;
         assign disp_ext = {{PAD_W{disp_i[DISP_W-1]}}, disp_i};
      end else begin : g_full
         assign disp_ext = disp_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (load) begin
         addr_q <= base_i + disp_ext;
      end
   end

   assign addr_o = addr_q;
endmodule

// File: rtl/bitset_merge.sv
// Builds the one-hot bit mask, extracts the old bit and merges the set bit.
module bitset_merge #(
   parameter int DATA_W = 8,
   localparam int BIT_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] old_i,
   input  logic [BIT_W-1:0]  sel_i,
   output logic [DATA_W-1:0] new_o,
   output logic              old_bit_o
);
   logic [DATA_W-1:0] mask;

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_mask
         assign mask[i] = (sel_i == BIT_W'(i));
      end
   endgenerate

   assign new_o     = old_i | mask;
   assign old_bit_o = |(old_i & mask);
endmodule

// File: rtl/bitset_seq.sv
// Four-step phase sequencer; accepts a request only when idle.
module bitset_seq
   import bitset_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   output logic   accept,
   output phase_t phase
);
   phase_t ph_q, ph_d;

   assign accept = start && (ph_q == PH_IDLE);

   always_comb begin
      ph_d = ph_q;
      unique case (ph_q)
         PH_IDLE:  if (start) ph_d = PH_ADDR;
         PH_ADDR:  ph_d = PH_READ;
         PH_READ:  ph_d = PH_WRITE;
         PH_WRITE: ph_d = PH_DONE;
         PH_DONE:  ph_d = PH_IDLE;
         default:  ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ph_q <= PH_IDLE;
      else        ph_q <= ph_d;
   end

   assign phase = ph_q;
endmodule

// File: rtl/bitset_rmw.sv
// Memory bit set read-modify-write top.
module bitset_rmw
   import bitset_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DISP_W = 16,
   parameter int DATA_W = 8,
   localparam int BIT_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base,
   input  logic [DISP_W-1:0] disp,
   input  logic [BIT_W-1:0]  bit_sel,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd_en,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_wr_en,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              z_flag,
   output logic              done
);
   generate
      if (DISP_W > ADDR_W) begin : g_bad_disp
         $error("bitset_rmw: DISP_W must not exceed ADDR_W");
      end
      if ((DATA_W < 2) || ((1 << BIT_W) != DATA_W)) begin : g_bad_data
         $error("bitset_rmw: DATA_W must be a power of two of at least 2");
      end
   endgenerate

   logic              accept;
   phase_t            phase;
   logic [ADDR_W-1:0] base_q;
   logic [DISP_W-1:0] disp_q;
   logic [BIT_W-1:0]  sel_q;
   logic              z_q;
   logic              old_bit;
   logic [DATA_W-1:0] merged;

   bitset_seq u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .accept (accept),
      .phase  (phase)
   );

   // Operands are captured once, at acceptance.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         disp_q <= '0;
         sel_q  <= '0;
      end else if (accept) begin
         base_q <= base;
         disp_q <= disp;
         sel_q  <= bit_sel;
      end
   end

   bitset_addr #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (phase == PH_ADDR),
      .base_i (base_q),
      .disp_i (disp_q),
      .addr_o (mem_addr)
   );

   bitset_merge #(.DATA_W(DATA_W)) u_merge (
      .old_i     (mem_rdata),
      .sel_i     (sel_q),
      .new_o     (merged),
      .old_bit_o (old_bit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                  z_q <= 1'b0;
      else if (phase == PH_WRITE)  z_q <= ~old_bit;
   end

   assign mem_rd_en = (phase == PH_READ);
   assign mem_wr_en = (phase == PH_WRITE);
   assign mem_wdata = merged;
   assign z_flag    = z_q;
   assign done      = (phase == PH_DONE);
endmodule

// File: rtl/bitset_rmw_chk.sv
// Property checker bound to bitset_rmw.
module bitset_rmw_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rd_en,
   input logic [DATA_W-1:0] mem_rdata,
   input logic              mem_wr_en,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              z_flag,
   input logic              done
);
   // R1: the cycle after a reset cycle is quiet
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!done && !mem_rd_en && !mem_wr_en && !z_flag));

   // R3: read is a single-cycle pulse
   a_r3_single_read: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> !mem_rd_en);

   // R2: address held from read into write
   a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> (mem_wr_en && $stable(mem_addr)));

   // R8: write only directly after a read
   a_r8_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> $past(mem_rd_en));

   // R4: write data keeps every read bit and adds at most one
   a_r4_merge_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> (((mem_wdata & mem_rdata) == mem_rdata)
                     && ($countones(mem_wdata ^ mem_rdata) <= 1)));

   // R6: done follows write and lasts one cycle
   a_r6_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |=> done);
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5: zero flag moves only in a done cycle
   a_r5_z_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(z_flag) |-> done);
endmodule

bind bitset_rmw bitset_rmw_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_addr  (mem_addr),
   .mem_rd_en (mem_rd_en),
   .mem_rdata (mem_rdata),
   .mem_wr_en (mem_wr_en),
   .mem_wdata (mem_wdata),
   .z_flag    (z_flag),
   .done      (done)
);

// File: tb/bitset_rmw_test.sv
module bitset_rmw_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] base = '0;
   logic [15:0] disp = '0;
   logic [2:0]  bit_sel = '0;
   logic [31:0] mem_addr;
   logic        mem_rd_en;
   logic [7:0]  mem_rdata;
   logic        mem_wr_en;
   logic [7:0]  mem_wdata;
   logic        z_flag;
   logic        done;

   int checks = 0;
   int failures = 0;
   int rd_count = 0;

   logic       pre_en = 1'b0;
   logic [7:0] pre_idx = '0;
   logic [7:0] pre_val = '0;
   logic [7:0] mem [256];
   logic [7:0] rdata_q = '0;

   always #10 clk = ~clk;   // 50 MHz

   bitset_rmw uut (
      .clk(clk), .rst_n(rst_n), .start(start), .base(base), .disp(disp),
      .bit_sel(bit_sel), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
      .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata),
      .z_flag(z_flag), .done(done)
   );

   // Synchronous byte memory model, indexed by the low address byte.
   always @(posedge clk) begin
      if (pre_en) mem[pre_idx] <= pre_val;
      if (mem_rd_en) rdata_q <= mem[mem_addr[7:0]];
      if (mem_wr_en) mem[mem_addr[7:0]] <= mem_wdata;
      if (mem_rd_en) rd_count <= rd_count + 1;
   end
   assign mem_rdata = rdata_q;

   typedef struct packed {
      logic [31:0] b;
      logic [15:0] d;
      logic [2:0]  bn;
      logic [7:0]  init;
      logic [31:0] ea;
      logic [7:0]  ew;
      logic        ez;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{32'h0000_0010, 16'h0005, 3'd0, 8'h00, 32'h0000_0015, 8'h01, 1'b1},
      '{32'h0000_0100, 16'hFFFF, 3'd7, 8'h80, 32'h0000_00FF, 8'h80, 1'b0},
      '{32'h1234_5678, 16'h8000, 3'd3, 8'hF7, 32'h1233_D678, 8'hFF, 1'b1},
      '{32'hFFFF_FFF0, 16'h0020, 3'd5, 8'h20, 32'h0000_0010, 8'h20, 1'b0},
      '{32'h0000_0000, 16'h7FFF, 3'd6, 8'hA5, 32'h0000_7FFF, 8'hE5, 1'b1},
      '{32'h0000_0040, 16'h0000, 3'd2, 8'hFB, 32'h0000_0040, 8'hFF, 1'b1}
   };

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // One operation, checked cycle by cycle. With hold set, start stays high
   // and the operands are scrambled until the done cycle (R7).
   task automatic run_op(input vec_t v, input bit hold);
      int rd_before;
      @(negedge clk);
      pre_en = 1'b1; pre_idx = v.ea[7:0]; pre_val = v.init;
      @(negedge clk);
      pre_en = 1'b0;
      start = 1'b1; base = v.b; disp = v.d; bit_sel = v.bn;
      rd_before = rd_count;
      @(negedge clk);              // address phase
      if (hold) begin base = 32'hDEAD_BEE0; disp = 16'h1234; bit_sel = ~v.bn; end
      else start = 1'b0;
      check(!mem_rd_en && !mem_wr_en && !done, "R3", "address phase quiet",
            {29'd0, mem_rd_en, mem_wr_en, done}, 32'd0);
      @(negedge clk);              // read phase
      check(mem_rd_en == 1'b1, "R3", "read enable", 32'(mem_rd_en), 32'd1);
      check(mem_addr == v.ea, "R2", "read address", mem_addr, v.ea);
      @(negedge clk);              // write phase
      check(mem_wr_en == 1'b1, "R4", "write enable", 32'(mem_wr_en), 32'd1);
      check(mem_wdata == v.ew, "R4", "write data", 32'(mem_wdata), 32'(v.ew));
      check(mem_addr == v.ea, "R2", "write address", mem_addr, v.ea);
      @(negedge clk);              // done cycle
      start = 1'b0;
      check(done == 1'b1, "R6", "done in fourth cycle", 32'(done), 32'd1);
      check(z_flag == v.ez, "R5", "zero flag", 32'(z_flag), 32'(v.ez));
      @(negedge clk);
      check(done == 1'b0, "R6", "done single pulse", 32'(done), 32'd0);
      check(mem[v.ea[7:0]] == v.ew, "R4", "stored byte",
            32'(mem[v.ea[7:0]]), 32'(v.ew));
      repeat (3) @(negedge clk);
      check(rd_count - rd_before == 1, "R7", "one read per request",
            32'(rd_count - rd_before), 32'd1);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      vec_t hv;
      logic zk;
      // R1: reset state
      repeat (3) @(negedge clk);
      check(!done && !mem_rd_en && !mem_wr_en && !z_flag, "R1", "outputs in reset",
            {28'd0, done, mem_rd_en, mem_wr_en, z_flag}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!done && !mem_rd_en && !mem_wr_en && !z_flag, "R1", "idle after reset",
            {28'd0, done, mem_rd_en, mem_wr_en, z_flag}, 32'd0);

      for (int i = 0; i < NV; i++) run_op(VECS[i], 1'b0);

      // R5: flag holds while idle
      zk = z_flag;
      repeat (5) @(negedge clk);
      check(z_flag == zk, "R5", "flag held while idle", 32'(z_flag), 32'(zk));

      // R7: start kept high with changing operands during the operation
      hv = '{32'h0000_0080, 16'h0001, 3'd1, 8'h02, 32'h0000_0081, 8'h02, 1'b0};
      run_op(hv, 1'b1);

      // R8: no write without a read while idle
      repeat (4) @(negedge clk);
      check(!mem_wr_en && !mem_rd_en, "R8", "no access while idle",
            {30'd0, mem_wr_en, mem_rd_en}, 32'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule